// File: doc/BRIEF.md
# Active Priority Nesting Tracker

This block keeps, for one processor, the record of which interrupt priority levels are currently being serviced, and from it the running priority that gates further preemption. Each active level is one bit in a bitmap. The bitmap is indexed by preemption level, which is the interrupt's group priority with its low bits dropped. The running priority is always rebuilt from the most urgent level still marked, so a nest of handlers unwinds in priority order.

When the interrupt selector offers a pending interrupt, it raises an acknowledge strobe carrying that interrupt's 8-bit priority and its ID. The tracker accepts the interrupt only if the priority is strictly more urgent (numerically smaller) than the running priority. On acceptance it masks the priority with the binary-point setting to get the group priority, marks that level active and raises the running priority to it. On refusal it returns the spurious ID 1023. An end-of-interrupt strobe retires the most urgent active level. A small write port sets the binary point. The running priority is a 9-bit output whose idle value, 0x100, is less urgent than every real priority.

The parameter `MIN_BP` (0 to 6) sets the smallest allowed binary point. The bitmap holds `128 >> MIN_BP` levels.

Top module: `apn_tracker`

## Requirements
- R1: After reset the running priority output is 0x100, no level is active and the binary point equals `MIN_BP`.
- R2: A binary-point write of a value below `MIN_BP` stores `MIN_BP`; any other 3-bit value is stored as written. The new value applies to acknowledges from the next cycle on.
- R3: The group priority of an acknowledged interrupt is its priority with bits [bp:0] cleared, where bp is the binary point. A binary point of 7 gives group priority 0.
- R4: An acknowledge is accepted only when the priority is strictly below the running priority. A refused acknowledge, or a cycle with no acknowledge, drives `ack_ok` low and `ack_resp_id` to 1023, and leaves the running priority unchanged.
- R5: An accepted acknowledge drives `ack_ok` high and echoes `ack_id` on `ack_resp_id` in the same cycle. It sets the level bit (group priority >> (MIN_BP+1)), and from the next cycle the running priority equals the group priority.
- R6: An end-of-interrupt clears the lowest set level bit. From the next cycle the running priority is (lowest remaining level) << (MIN_BP+1), or 0x100 if no level remains.
- R7: An end-of-interrupt is ignored when the running priority is 0x100 or when its ID is not below `NUM_SRC`, including ID 1023.
- R8: When an acknowledge and an end-of-interrupt arrive in the same cycle, the acknowledge is judged against the running priority before the end-of-interrupt. Both updates then apply to the bitmap.
- R9: The running priority is always either exactly 0x100 or a value below 0x100 whose low MIN_BP+1 bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_req | input | 1 | Acknowledge request strobe |
| ack_prio | input | 8 | Priority of the interrupt being acknowledged |
| ack_id | input | ID_W | ID of the interrupt being acknowledged |
| ack_ok | output | 1 | Acknowledge accepted (same cycle) |
| ack_resp_id | output | ID_W | Accepted ID, or 1023 |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_id | input | ID_W | ID carried by the end-of-interrupt |
| bp_we | input | 1 | Binary-point write enable |
| bp_wdata | input | 3 | Binary-point write value |
| run_prio | output | 9 | Running priority, 0x100 when idle |

## Verification
Two pairs of functions can land in the same cycle: an acknowledge with an end-of-interrupt, and an acknowledge with a binary-point write. The bench drives each pair together from a state with one level already active. It uses both a priority that beats the pre-retirement running priority and one that only ties it, so the tie must be refused even though the retirement empties the bitmap. A reference model in the bench updates its own bitmap in the order stated in R8 and R2, and the running priority of the next cycle is compared against that model.

// File: rtl/apn_pkg.sv
package apn_pkg;
    localparam int PRIO_W = 8;
    localparam int RUN_W  = 9;
    localparam int BP_W   = 3;
    localparam logic [RUN_W-1:0] RUN_IDLE = 9'h100;

    // Clear priority bits [bp:0]; bp = 7 clears the whole byte.
    function automatic logic [PRIO_W-1:0] mask_group(input logic [PRIO_W-1:0] prio,
                                                     input logic [BP_W-1:0]   bp);
        logic [8:0] keep;
        keep = 9'h1FF << ({1'b0, bp} + 4'd1);
        return prio & keep[PRIO_W-1:0];
    endfunction
endpackage

// File: rtl/apn_level_calc.sv
module apn_level_calc
    import apn_pkg::*;
#(
    parameter int MIN_BP = 2,
    localparam int SHIFT = MIN_BP + 1,
    localparam int LVL_W = PRIO_W - SHIFT
) (
    input  logic [PRIO_W-1:0] prio,
    input  logic [BP_W-1:0]   bp,
    output logic [LVL_W-1:0]  level
);
    logic [PRIO_W-1:0] grp;

    always_comb begin
        grp   = mask_group(prio, bp);
        level = LVL_W'(grp >> SHIFT);
    end
endmodule

// File: rtl/apn_lowest_find.sv
module apn_lowest_find #(
    parameter int N = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     bits,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/apn_tracker.sv
module apn_tracker
    import apn_pkg::*;
#(
    parameter int MIN_BP  = 2,
    parameter int NUM_SRC = 64,
    parameter int ID_W    = 10,
    localparam int SHIFT  = MIN_BP + 1,
    localparam int LVL_W  = PRIO_W - SHIFT,
    localparam int NLVL   = 1 << LVL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ack_req,
    input  logic [PRIO_W-1:0]   ack_prio,
    input  logic [ID_W-1:0]     ack_id,
    output logic                ack_ok,
    output logic [ID_W-1:0]     ack_resp_id,
    input  logic                eoi_valid,
    input  logic [ID_W-1:0]     eoi_id,
    input  logic                bp_we,
    input  logic [BP_W-1:0]     bp_wdata,
    output logic [RUN_W-1:0]    run_prio
);
    localparam logic [BP_W-1:0] BP_MIN   = BP_W'(MIN_BP);
    localparam logic [ID_W-1:0] ID_SPUR  = ID_W'(1023);

    typedef struct packed {
        logic [NLVL-1:0]  act;
        logic [RUN_W-1:0] run;
        logic [BP_W-1:0]  bp;
    } state_t;

    state_t st_q, st_d;

    logic [LVL_W-1:0] ack_level;
    logic [NLVL-1:0]  act_after_eoi;
    logic [NLVL-1:0]  act_next;
    logic             next_any;
    logic [LVL_W-1:0] next_idx;
    logic             eoi_take;

    apn_level_calc #(.MIN_BP(MIN_BP)) u_level (
        .prio  (ack_prio),
        .bp    (st_q.bp),
        .level (ack_level)
    );

    apn_lowest_find #(.N(NLVL)) u_find (
        .bits (act_next),
        .any  (next_any),
        .idx  (next_idx)
    );

    always_comb begin
        // Acceptance is judged against the registered running priority.
        ack_ok      = ack_req && ({1'b0, ack_prio} < st_q.run);
        ack_resp_id = ack_ok ? ack_id : ID_SPUR;

        eoi_take = eoi_valid && (st_q.run != RUN_IDLE)
                   && ({22'd0, eoi_id} < 32'(NUM_SRC));

        // Retire the most urgent level first, then mark the new one.
        act_after_eoi = eoi_take ? (st_q.act & (st_q.act - NLVL'(1))) : st_q.act;
        act_next      = act_after_eoi | (ack_ok ? (NLVL'(1) << ack_level) : '0);

        st_d     = st_q;
        st_d.act = act_next;
        st_d.run = next_any ? {1'b0, next_idx, {SHIFT{1'b0}}} : RUN_IDLE;
        if (bp_we) begin
            st_d.bp = (bp_wdata < BP_MIN) ? BP_MIN : bp_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.act <= '0;
            st_q.run <= RUN_IDLE;
            st_q.bp  <= BP_MIN;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_prio = st_q.run;
endmodule

// File: rtl/apn_tracker_chk.sv
module apn_tracker_chk #(
    parameter int MIN_BP  = 2,
    parameter int NUM_SRC = 64,
    parameter int ID_W    = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ack_req,
    input logic [7:0]      ack_prio,
    input logic            ack_ok,
    input logic [ID_W-1:0] ack_resp_id,
    input logic            eoi_valid,
    input logic [ID_W-1:0] eoi_id,
    input logic [8:0]      run_prio
);
    localparam int SH = MIN_BP + 1;

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> run_prio == 9'h100);

    assert_accept_rule_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_ok |-> ({1'b0, ack_prio} < run_prio));

    assert_refuse_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_ok |-> ack_resp_id == ID_W'(1023));

    assert_accept_raises_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_ok |=> (run_prio <= {1'b0, $past(ack_prio)}) && (run_prio < $past(run_prio)));

    assert_eoi_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && !ack_req && run_prio != 9'h100 && 32'(eoi_id) < NUM_SRC)
        |=> run_prio > $past(run_prio));

    assert_eoi_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && !ack_req && (run_prio == 9'h100 || 32'(eoi_id) >= NUM_SRC))
        |=> $stable(run_prio));

    assert_run_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
        run_prio[8] ? (run_prio[7:0] == 8'h00) : (run_prio[SH-1:0] == '0));
endmodule

bind apn_tracker apn_tracker_chk #(.MIN_BP(MIN_BP), .NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_req     (ack_req),
    .ack_prio    (ack_prio),
    .ack_ok      (ack_ok),
    .ack_resp_id (ack_resp_id),
    .eoi_valid   (eoi_valid),
    .eoi_id      (eoi_id),
    .run_prio    (run_prio)
);

// File: tb/apn_tracker_tb.sv
module apn_tracker_tb;
    localparam int MINB = 2;
    localparam int NSRC = 64;
    localparam int NL   = 128 >> MINB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ack_req = 1'b0;
    logic [7:0] ack_prio = '0;
    logic [9:0] ack_id = '0;
    logic       ack_ok;
    logic [9:0] ack_resp_id;
    logic       eoi_valid = 1'b0;
    logic [9:0] eoi_id = '0;
    logic       bp_we = 1'b0;
    logic [2:0] bp_wdata = '0;
    logic [8:0] run_prio;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit [NL-1:0] m_act = '0;
    int          m_bp  = MINB;
    int          m_run = 256;

    always #10 clk = ~clk;

    apn_tracker #(.MIN_BP(MINB), .NUM_SRC(NSRC), .ID_W(10)) u_dut (
        .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .ack_prio(ack_prio),
        .ack_id(ack_id), .ack_ok(ack_ok), .ack_resp_id(ack_resp_id),
        .eoi_valid(eoi_valid), .eoi_id(eoi_id), .bp_we(bp_we),
        .bp_wdata(bp_wdata), .run_prio(run_prio)
    );

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
        end
    endtask

    function automatic int grp(int p, int b);
        return p & ~((1 << (b + 1)) - 1) & 255;
    endfunction

    function automatic int model_run();
        for (int i = 0; i < NL; i++) if (m_act[i]) return i << (MINB + 1);
        return 256;
    endfunction

    task automatic step(bit a, int pr, int id, bit e, int eid, bit bw, int bd, string tag);
        bit exp_ok;
        @(negedge clk);
        ack_req = a; ack_prio = pr[7:0]; ack_id = id[9:0];
        eoi_valid = e; eoi_id = eid[9:0]; bp_we = bw; bp_wdata = bd[2:0];
        #1;
        exp_ok = a && (pr < m_run);
        chk({tag, " ack_ok"}, int'(ack_ok), int'(exp_ok));
        chk({tag, " resp"}, int'(ack_resp_id), exp_ok ? id : 1023);
        // model: retire first, then mark with the old binary point
        if (e && m_run != 256 && eid < NSRC) m_act = m_act & (m_act - 1);
        if (exp_ok) m_act[grp(pr, m_bp) >> (MINB + 1)] = 1'b1;
        if (bw) m_bp = ((bd & 7) < MINB) ? MINB : (bd & 7);
        m_run = model_run();
        @(posedge clk); #1;
        ack_req = 1'b0; eoi_valid = 1'b0; bp_we = 1'b0;
        chk({tag, " run"}, int'(run_prio), m_run);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1; chk("R1 reset run", int'(run_prio), 256);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1; chk("R1 idle after reset", int'(run_prio), 256);

        // R1: reset bp is MIN: prio 0x3F acknowledged gives 0x38
        step(1, 8'h3F, 3, 0, 0, 0, 0, "R1 bp reset");
        chk("R1 bp reset grp", int'(run_prio), 8'h38);
        step(0, 0, 0, 1, 3, 0, 0, "R6 unwind");

        // R2/R3/R5/R6: sweep every binary point and priority
        for (int b = 0; b < 8; b++) begin
            step(0, 0, 0, 0, 0, 1, b, "R2 bp write");
            for (int p = 0; p < 256; p++) begin
                step(1, p, p % NSRC, 0, 0, 0, 0, "R3 R5 sweep");
                chk("R3 group prio", int'(run_prio), grp(p, (b < MINB) ? MINB : b));
                step(0, 0, 0, 1, p % NSRC, 0, 0, "R6 single drop");
            end
        end

        // R3: bp 7 -> group prio 0
        step(0, 0, 0, 0, 0, 1, 7, "R2 bp7");
        step(1, 8'hFE, 9, 0, 0, 0, 0, "R3 bp7");
        chk("R3 bp7 zero", int'(run_prio), 0);
        step(1, 8'h00, 9, 0, 0, 0, 0, "R4 refuse tie at 0");
        step(0, 0, 0, 1, 9, 0, 0, "R6 bp7 drop");

        // Nesting at minimum bp
        step(0, 0, 0, 0, 0, 1, 0, "R2 clamp to min");
        step(1, 8'hC3, 1, 0, 0, 0, 0, "R5 nest1");
        step(1, 8'hC0, 2, 0, 0, 0, 0, "R4 refuse tie");
        step(1, 8'hE0, 2, 0, 0, 0, 0, "R4 refuse less urgent");
        step(1, 8'h85, 2, 0, 0, 0, 0, "R5 nest2");
        step(1, 8'h41, 3, 0, 0, 0, 0, "R5 nest3");
        step(1, 8'h08, 4, 0, 0, 0, 0, "R5 nest4");
        chk("R5 nest top", int'(run_prio), 8'h08);
        step(0, 0, 0, 1, 1023, 0, 0, "R7 spurious eoi");
        step(0, 0, 0, 1, NSRC, 0, 0, "R7 out of range eoi");
        step(0, 0, 0, 1, 4, 0, 0, "R6 drop to 0x40");
        chk("R6 level 0x40", int'(run_prio), 8'h40);
        step(0, 0, 0, 1, 3, 0, 0, "R6 drop to 0x80");
        step(0, 0, 0, 1, 2, 0, 0, "R6 drop to 0xC0");
        step(0, 0, 0, 1, 1, 0, 0, "R6 drop to idle");
        chk("R6 idle", int'(run_prio), 256);
        step(0, 0, 0, 1, 5, 0, 0, "R7 eoi when idle");

        // R8: same-cycle ack + eoi
        step(1, 8'h80, 7, 0, 0, 0, 0, "R8 setup");
        step(1, 8'h20, 8, 1, 7, 0, 0, "R8 ack beats old run");
        chk("R8 new run", int'(run_prio), 8'h20);
        step(1, 8'h20, 9, 1, 8, 0, 0, "R8 tie refused though eoi empties");
        chk("R8 emptied", int'(run_prio), 256);
        // R8/R2: bp write with ack in same cycle uses old bp
        step(1, 8'h5F, 10, 0, 0, 1, 6, "R8 R2 ack with bp write");
        chk("R8 old bp used", int'(run_prio), 8'h58);
        step(1, 8'h3F, 11, 0, 0, 0, 0, "R2 new bp6");
        chk("R2 new bp applied", int'(run_prio), 0);
        step(0, 0, 0, 1, 11, 0, 0, "R6 pop");
        step(0, 0, 0, 1, 10, 0, 0, "R6 pop2");
        chk("R6 empty end", int'(run_prio), 256);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule